// File: doc/BRIEF.md
# DTR Pin Mode Controller

This block produces the active-low DTR pin of a serial port. A 2-bit mode field selects what the pin means. In software mode the pin follows a control bit. In flow-control mode the pin tells the far end to pause when the local receive FIFO fills, and to resume once the FIFO has drained, with hysteresis between two thresholds. In the two line-driver modes the pin enables an external half-duplex RS485 transceiver while the transmitter is busy. The driver enable is active low in one of these modes and active high in the other.

Two small state machines do the work. The flow machine has two states: `FLOW_GO` (peer may send) and `FLOW_STOP` (peer paused). The direction machine has three states: `DIR_IDLE` (driver off), `DIR_SEND` (characters pending) and `DIR_DRAIN` (transmitter empty, line not yet back at idle).

Both machines expose their next state. The pin register captures the value chosen for the selected mode, so in every mode the pin reflects the inputs from the previous clock edge, one cycle late.

Top module: `dtr_mode_ctrl`

State transitions:
- `FLOW_GO` to `FLOW_STOP`: the mode is flow control and the level is greater than or equal to the upper threshold.
- `FLOW_STOP` to `FLOW_GO`: the level is below the lower threshold, or the mode is not flow control.
- `DIR_IDLE` to `DIR_SEND`: the transmitter is not empty.
- `DIR_SEND` to `DIR_IDLE`: the transmitter is empty and the line is idle.
- `DIR_SEND` to `DIR_DRAIN`: the transmitter is empty and the line is not idle.
- `DIR_DRAIN` to `DIR_SEND`: the transmitter is not empty.
- `DIR_DRAIN` to `DIR_IDLE`: the line is idle.

## Requirements
- R1: While `rst_n` is low, `dtr_n` is 1. The flow machine resets to `FLOW_GO` and the direction machine resets to `DIR_IDLE`.
- R2: With `mode_sel` = 00, `dtr_n` equals the inverse of `sw_dtr` one cycle later. A `sw_dtr` of 1 asserts DTR, which drives the pin low.
- R3: With `mode_sel` = 01, a `rx_level` greater than or equal to `thr_hi` makes `dtr_n` 1 in the next cycle.
- R4: With `mode_sel` = 01 and the pin paused, a `rx_level` at or above `thr_lo` keeps `dtr_n` at 1.
- R5: With `mode_sel` = 01, a `rx_level` below `thr_lo` makes `dtr_n` 0 in the next cycle, unless the level is also at or above `thr_hi`.
- R6: Any cycle with `mode_sel` other than 01 returns the flow machine to `FLOW_GO`. On re-entering mode 01 with `rx_level` below `thr_hi`, the pin is 0.
- R7: With `mode_sel` = 10, `tx_empty` = 0 makes `dtr_n` 0 in the next cycle.
- R8: With `mode_sel` = 11, `tx_empty` = 0 makes `dtr_n` 1 in the next cycle.
- R9: After the transmitter becomes empty, the driver enable stays asserted for as long as `sout_idle` is 0.
- R10: With `tx_empty` = 1 and `sout_idle` = 1, the driver enable is released in the next cycle. In mode 10 this means `dtr_n` = 1; in mode 11 it means `dtr_n` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Pin mode: 00 software, 01 flow control, 10 active-low driver enable, 11 active-high driver enable |
| sw_dtr | input | 1 | Software DTR bit; 1 asserts DTR (pin low) |
| rx_level | input | LVL_W | Receive FIFO fill level |
| thr_hi | input | LVL_W | Upper flow threshold (pause) |
| thr_lo | input | LVL_W | Lower flow threshold (resume) |
| tx_empty | input | 1 | Transmitter FIFO and shift register both empty |
| sout_idle | input | 1 | Serial output is at its idle marking level |
| dtr_n | output | 1 | Registered active-low DTR pin |

## Verification
The hardest cases to reach are the hidden hysteresis and drain states. From the ports, a paused flow machine and a draining direction machine look the same as their neighbouring states. They only differ in what the next input does.

The stimulus reaches them with planned sequences:
- Fill the FIFO past the upper threshold, then hover between the two thresholds.
- Leave flow mode while paused, then return to it with a level between the thresholds.
- Empty the transmitter while the line stays busy for several cycles, then refill it before the line goes idle.

The scoreboard's model tracks both hidden states, so every step has a defined expected pin value.

// File: rtl/dtr_pkg.sv
package dtr_pkg;

    typedef enum logic [1:0] {
        DTR_SW     = 2'b00,
        DTR_FLOW   = 2'b01,
        DTR_DIR_LO = 2'b10,
        DTR_DIR_HI = 2'b11
    } dtr_mode_e;

    typedef enum logic {
        FLOW_GO   = 1'b0,
        FLOW_STOP = 1'b1
    } flow_state_e;

    typedef enum logic [1:0] {
        DIR_IDLE  = 2'b00,
        DIR_SEND  = 2'b01,
        DIR_DRAIN = 2'b10
    } dir_state_e;

endpackage

// File: rtl/dtr_flow_fsm.sv
module dtr_flow_fsm
    import dtr_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] thr_hi,
    input  logic [LVL_W-1:0] thr_lo,
    output logic             stop_nxt
);

    flow_state_e state_q, state_d;
    logic        at_hi, below_lo;

    assign at_hi    = (level >= thr_hi);
    assign below_lo = (level < thr_lo);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = FLOW_GO;
        end else begin
            unique case (state_q)
                FLOW_GO:   if (at_hi)                state_d = FLOW_STOP;
                FLOW_STOP: if (below_lo && !at_hi)   state_d = FLOW_GO;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLOW_GO;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        stop_nxt = (state_d == FLOW_STOP);
    end

endmodule

// File: rtl/dtr_dir_fsm.sv
module dtr_dir_fsm
    import dtr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_empty,
    input  logic line_idle,
    output logic drive_nxt
);

    dir_state_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DIR_IDLE: begin
                if (!tx_empty) state_d = DIR_SEND;
            end
            DIR_SEND: begin
                if (tx_empty) state_d = line_idle ? DIR_IDLE : DIR_DRAIN;
            end
            DIR_DRAIN: begin
                if (!tx_empty)     state_d = DIR_SEND;
                else if (line_idle) state_d = DIR_IDLE;
            end
            default: state_d = DIR_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DIR_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        drive_nxt = (state_d != DIR_IDLE);
    end

endmodule

// File: rtl/dtr_mode_ctrl.sv
module dtr_mode_ctrl
    import dtr_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_sel,
    input  logic             sw_dtr,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] thr_hi,
    input  logic [LVL_W-1:0] thr_lo,
    input  logic             tx_empty,
    input  logic             sout_idle,
    output logic             dtr_n
);

    dtr_mode_e mode;
    logic      flow_stop;
    logic      drive_on;
    logic      pin_d;

    assign mode = dtr_mode_e'(mode_sel);

    dtr_flow_fsm #(.LVL_W(LVL_W)) u_flow (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (mode == DTR_FLOW),
        .level    (rx_level),
        .thr_hi   (thr_hi),
        .thr_lo   (thr_lo),
        .stop_nxt (flow_stop)
    );

    dtr_dir_fsm u_dir (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_empty  (tx_empty),
        .line_idle (sout_idle),
        .drive_nxt (drive_on)
    );

    always_comb begin
        unique case (mode)
            DTR_SW:     pin_d = ~sw_dtr;
            DTR_FLOW:   pin_d = flow_stop;
            DTR_DIR_LO: pin_d = ~drive_on;
            DTR_DIR_HI: pin_d = drive_on;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dtr_n <= 1'b1;
        else        dtr_n <= pin_d;
    end

endmodule

// File: rtl/dtr_mode_ctrl_chk.sv
module dtr_mode_ctrl_chk #(
    parameter int LVL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_sel,
    input logic             sw_dtr,
    input logic [LVL_W-1:0] rx_level,
    input logic [LVL_W-1:0] thr_hi,
    input logic [LVL_W-1:0] thr_lo,
    input logic             tx_empty,
    input logic             sout_idle,
    input logic             dtr_n
);

    p_reset_high_r1: assert property (@(posedge clk)
        !rst_n |=> dtr_n);

    p_sw_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b00) |=> (dtr_n == !$past(sw_dtr)));

    p_flow_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b01 && rx_level >= thr_hi) |=> dtr_n);

    p_flow_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b01 && $past(mode_sel) == 2'b01 && dtr_n && rx_level >= thr_lo)
        |=> dtr_n);

    p_flow_resume_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b01 && rx_level < thr_lo && rx_level < thr_hi) |=> !dtr_n);

    p_flow_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b01 && $past(mode_sel) != 2'b01 && rx_level < thr_hi)
        |=> !dtr_n);

    p_dir_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b10 && !tx_empty) |=> !dtr_n);

    p_dir_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b11 && !tx_empty) |=> dtr_n);

    p_drain_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b10 && $past(mode_sel) == 2'b10 && !dtr_n && !sout_idle)
        |=> !dtr_n);

    p_release_lo_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b10 && tx_empty && sout_idle) |=> dtr_n);

    p_release_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b11 && tx_empty && sout_idle) |=> !dtr_n);

endmodule

bind dtr_mode_ctrl dtr_mode_ctrl_chk #(.LVL_W(LVL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_sel  (mode_sel),
    .sw_dtr    (sw_dtr),
    .rx_level  (rx_level),
    .thr_hi    (thr_hi),
    .thr_lo    (thr_lo),
    .tx_empty  (tx_empty),
    .sout_idle (sout_idle),
    .dtr_n     (dtr_n)
);

// File: tb/tb_dtr_mode_ctrl.sv
`timescale 1ns/1ps
module tb_dtr_mode_ctrl;

    localparam int LVL_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       mode_sel = 2'b00;
    logic             sw_dtr = 1'b0;
    logic [LVL_W-1:0] rx_level = '0;
    logic [LVL_W-1:0] thr_hi = 8'd12;
    logic [LVL_W-1:0] thr_lo = 8'd4;
    logic             tx_empty = 1'b1;
    logic             sout_idle = 1'b1;
    logic             dtr_n;

    int tests = 0;
    int fails = 0;

    bit    exp_q[$];
    string tag_q[$];

    // bench model state
    bit m_stop = 1'b0;
    bit m_on   = 1'b0;

    always #2 clk = ~clk;

    dtr_mode_ctrl #(.LVL_W(LVL_W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .sw_dtr    (sw_dtr),
        .rx_level  (rx_level),
        .thr_hi    (thr_hi),
        .thr_lo    (thr_lo),
        .tx_empty  (tx_empty),
        .sout_idle (sout_idle),
        .dtr_n     (dtr_n)
    );

    task automatic check(input bit exp, input string tag);
        tests++;
        if (dtr_n !== exp) begin
            fails++;
            $display("FAIL %s: dtr_n=%b expected %b", tag, dtr_n, exp);
        end
    endtask

    // driver: apply inputs at negedge, push model expectation
    task automatic step(input logic [1:0] m, input bit sw, input int lvl,
                        input bit txe, input bit idle, input string tag);
        bit e;
        @(negedge clk);
        mode_sel  = m;
        sw_dtr    = sw;
        rx_level  = LVL_W'(lvl);
        tx_empty  = txe;
        sout_idle = idle;
        if (m != 2'b01)                         m_stop = 1'b0;
        else if (lvl >= int'(thr_hi))           m_stop = 1'b1;
        else if (m_stop && lvl < int'(thr_lo))  m_stop = 1'b0;
        if (!txe)      m_on = 1'b1;
        else if (idle) m_on = 1'b0;
        unique case (m)
            2'b00: e = !sw;
            2'b01: e = m_stop;
            2'b10: e = !m_on;
            2'b11: e = m_on;
        endcase
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // monitor: compare one item per clock, after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                bit    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(e, t);
            end
        end
    end

    initial begin
        #(4 * 5000);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(1'b1, "R1 reset pin high");
        @(negedge clk);
        rst_n = 1'b1;

        // R1: flow machine starts in GO
        step(2'b01, 0, 8, 1, 1, "R1 flow reset state");
        // R2: software mode
        step(2'b00, 1, 0, 1, 1, "R2 sw assert");
        step(2'b00, 0, 0, 1, 1, "R2 sw deassert");
        step(2'b00, 1, 0, 0, 0, "R2 sw ignores tx");
        step(2'b00, 0, 50, 1, 1, "R2 sw ignores level");
        // R3/R4/R5: hysteresis
        step(2'b01, 0, 2, 1, 1, "R5 low level");
        step(2'b01, 0, 11, 1, 1, "R4 below hi still go");
        step(2'b01, 0, 12, 1, 1, "R3 reach hi");
        step(2'b01, 0, 20, 1, 1, "R3 above hi");
        step(2'b01, 0, 8, 1, 1, "R4 hold between");
        step(2'b01, 0, 4, 1, 1, "R4 hold at lo");
        step(2'b01, 0, 3, 1, 1, "R5 below lo resume");
        step(2'b01, 0, 8, 1, 1, "R4 go between");
        step(2'b01, 0, 13, 1, 1, "R3 stop again");
        // R6: leave mode while paused, come back between thresholds
        step(2'b00, 1, 8, 1, 1, "R6 leave flow");
        step(2'b01, 0, 8, 1, 1, "R6 reentry cleared");
        step(2'b01, 0, 0, 1, 1, "R5 zero level");
        // R7/R9/R10: active-low driver enable
        step(2'b10, 0, 0, 1, 1, "R10 idle released lo");
        step(2'b10, 0, 0, 0, 0, "R7 busy enable low");
        step(2'b10, 0, 0, 0, 1, "R7 busy line idle");
        step(2'b10, 0, 0, 1, 0, "R9 drain hold 1");
        step(2'b10, 0, 0, 1, 0, "R9 drain hold 2");
        step(2'b10, 0, 0, 1, 0, "R9 drain hold 3");
        step(2'b10, 0, 0, 0, 0, "R7 refill in drain");
        step(2'b10, 0, 0, 1, 0, "R9 drain again");
        step(2'b10, 0, 0, 1, 1, "R10 release lo");
        step(2'b10, 0, 0, 1, 0, "R10 stays released");
        // R8/R9/R10: active-high driver enable
        step(2'b11, 0, 0, 1, 1, "R10 idle released hi");
        step(2'b11, 0, 0, 0, 0, "R8 busy enable high");
        step(2'b11, 0, 0, 1, 0, "R9 drain hold hi");
        step(2'b11, 0, 0, 1, 0, "R9 drain hold hi 2");
        step(2'b11, 0, 0, 1, 1, "R10 release hi");
        // mode change while draining keeps direction state
        step(2'b11, 0, 0, 0, 0, "R8 busy again");
        step(2'b10, 0, 0, 1, 0, "R9 drain across mode");
        step(2'b10, 0, 0, 1, 1, "R10 release after switch");
        step(2'b00, 0, 0, 1, 1, "R2 back to sw");

        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule